// File: doc/BRIEF.md
# Block Command Decoder and Row Sequencer

This block takes 192-bit block command words from a valid/ready side-band stream on the receive side of a display data path. Each accepted word is checked. A word with a non-zero header byte, an unknown operation code, or an illegal row count is consumed and then discarded without any other effect. A dropped word only advances a saturating drop counter. A good word is latched, and it starts a row sequencer.

While the sequencer runs, it emits one absolute row index per clock, together with a row strobe. The indices cover the rows written inside the addressed block. A load operation covers the requested number of rows. It runs upward from row 1, or downward from the last row when the flip bit is set. Clear and set operations always cover the whole block in ascending order. They ignore the row count and the flip bit. The block address, the operation and the effective segment stay on the outputs for the downstream pixel path. The input stream is stalled while a sequence is running. A one-cycle done pulse follows the last row.

Top module: `blk_cmd_sequencer`

## Requirements
- R1: A word whose bits [7:0] are not all zero is consumed and dropped: no row strobe, no done pulse, and the drop counter advances by one.
- R2: A load word (bits [34:32] = 000) whose row count in bits [24:16] is 0 or greater than 136 is dropped in the same way as in R1.
- R3: A word with an operation code in bits [34:32] of 011 to 111 is dropped in the same way as in R1.
- R4: `cmd_ready_o` is high whenever no sequence is running and low while one runs. A word is taken only on a clock edge where valid and ready are both high. A word offered while ready is low has no effect.
- R5: A good load word with flip bit [36] = 0 and row count N gives N consecutive cycles of `row_vld_o`. These begin in the cycle after acceptance, with `row_idx_o` = 1, 2, …, N.
- R6: A good load word with flip bit [36] = 1 and row count N gives `row_idx_o` = 136, 135, …, 137−N on consecutive cycles.
- R7: A clear word (001) or set word (010) gives 136 ascending rows, 1 to 136, whatever the row count and flip fields hold. `op_o` reads 0 for load, 1 for clear and 2 for set.
- R8: `blk_addr_o` shows bits [11:8] of the last accepted good word from the cycle after acceptance.
- R9: `seg_o` shows bits [29:28] when bit [30] (single-channel) is 1 and reads 0 when bit [30] is 0.
- R10: `done_o` is high for exactly one cycle, in the cycle right after the last row. `busy_o` and `row_vld_o` are low in that cycle.
- R11: After reset, `cmd_ready_o` = 1, `busy_o` = 0 and the drop counter = 0. The counter saturates at its all-ones value. Bits outside the defined fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_data_i | input | 192 | Block command word |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_ready_o | output | 1 | Block can take a command word |
| blk_addr_o | output | 4 | Block address of the current operation |
| op_o | output | 2 | Operation: 0 load, 1 clear, 2 set |
| seg_o | output | 2 | Effective segment, 0 unless single-channel |
| busy_o | output | 1 | A row sequence is in progress |
| row_vld_o | output | 1 | Row strobe, one cycle per row |
| row_idx_o | output | 8 | Absolute row index, 1 to 136 |
| done_o | output | 1 | One-cycle pulse after the last row |
| drop_cnt_o | output | DROP_W | Saturating count of dropped words |

## Verification
Corrupted state in the remaining-row counter would appear in the first sequence. The done pulse and the rise of `cmd_ready_o` would come on the wrong cycle, or `row_idx_o` would leave its expected run. A flipped direction bit would be seen on the first step after the starting row. A decoder fault would be seen one cycle after the handshake. Either a dropped word would start strobes, or a good word would bump the drop counter instead of raising `busy_o`.

// File: rtl/blk_cmd_pkg.sv
package blk_cmd_pkg;
  localparam int CMD_W    = 192;
  localparam int BLK_ROWS = 136;
  localparam int ROW_W    = $clog2(BLK_ROWS + 1);
  localparam int ADDR_W   = 4;
  localparam int SEG_W    = 2;
  localparam int CNT_FW   = 9;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_SET   = 2'd2
  } op_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    op_e               op;
    logic [SEG_W-1:0]  seg;
    logic              down;
    logic [ROW_W-1:0]  count;
  } job_t;
endpackage

// File: rtl/blk_cmd_decode.sv
module blk_cmd_decode
  import blk_cmd_pkg::*;
#(
  parameter int ROWS = BLK_ROWS
) (
  input  logic [CMD_W-1:0] word_i,
  output logic             ok_o,
  output job_t             job_o
);
  logic [7:0]        hdr;
  logic [CNT_FW-1:0] cnt_f;
  logic [2:0]        typ;
  logic              single, flip, type_ok, cnt_ok;
  logic              unused_rsvd;

  assign hdr    = word_i[7:0];
  assign cnt_f  = word_i[24:16];
  assign single = word_i[30];
  assign typ    = word_i[34:32];
  assign flip   = word_i[36];
  assign unused_rsvd = ^{word_i[CMD_W-1:37], word_i[35], word_i[31],
                         word_i[27:25], word_i[15:12]};

  always_comb begin
    job_o.addr  = word_i[11:8];
    job_o.seg   = single ? word_i[29:28] : '0;
    job_o.op    = OP_LOAD;
    job_o.down  = 1'b0;
    job_o.count = ROW_W'(ROWS);
    type_ok     = 1'b1;
    cnt_ok      = 1'b1;
    case (typ)
      3'b000: begin
        job_o.down  = flip;
        job_o.count = cnt_f[ROW_W-1:0];
        cnt_ok      = (cnt_f != '0) && (cnt_f <= CNT_FW'(ROWS));
      end
      3'b001:  job_o.op = OP_CLEAR;
      3'b010:  job_o.op = OP_SET;
      default: type_ok  = 1'b0;
    endcase
    ok_o = (hdr == 8'h00) && type_ok && cnt_ok;
  end

  always_comb begin
    if (ok_o) assert_ok_fields_R7: assert (job_o.count != '0 && job_o.count <= ROW_W'(ROWS));
  end
endmodule

// File: rtl/blk_row_gen.sv
module blk_row_gen
  import blk_cmd_pkg::*;
#(
  parameter int ROWS = BLK_ROWS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  job_t             job_i,
  output logic             busy_o,
  output logic [ROW_W-1:0] row_o,
  output logic             done_o,
  output logic [ADDR_W-1:0] addr_o,
  output op_e              op_o,
  output logic [SEG_W-1:0] seg_o
);
  logic             busy_q, down_q, done_q, last;
  logic [ROW_W-1:0] row_q, left_q;

  assign last = (left_q == ROW_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      down_q <= 1'b0;
      done_q <= 1'b0;
      row_q  <= '0;
      left_q <= '0;
      addr_o <= '0;
      op_o   <= OP_LOAD;
      seg_o  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        down_q <= job_i.down;
        row_q  <= job_i.down ? ROW_W'(ROWS) : ROW_W'(1);
        left_q <= job_i.count;
        addr_o <= job_i.addr;
        op_o   <= job_i.op;
        seg_o  <= job_i.seg;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          row_q  <= down_q ? row_q - ROW_W'(1) : row_q + ROW_W'(1);
          left_q <= left_q - ROW_W'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign row_o  = row_q;
  assign done_o = done_q;

  assert_up_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !down_q && !last && !start_i |=> row_q == $past(row_q) + ROW_W'(1));
  assert_down_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && down_q && !last && !start_i |=> row_q == $past(row_q) - ROW_W'(1));
  assert_row_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> row_q >= ROW_W'(1) && row_q <= ROW_W'(ROWS));
  assert_done_after_last_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && last && !start_i |=> done_q && !busy_q);
  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/blk_drop_cnt.sv
module blk_drop_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic sat;
  assign sat = &cnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (inc_i && !sat) cnt_o <= cnt_o + W'(1);
  end

  assert_drop_inc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !sat |=> cnt_o == $past(cnt_o) + W'(1));
  assert_drop_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i || sat |=> $stable(cnt_o));
endmodule

// File: rtl/blk_cmd_sequencer.sv
module blk_cmd_sequencer
  import blk_cmd_pkg::*;
#(
  parameter int ROWS   = BLK_ROWS,
  parameter int DROP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CMD_W-1:0]  cmd_data_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  output logic [ADDR_W-1:0] blk_addr_o,
  output logic [1:0]        op_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic              busy_o,
  output logic              row_vld_o,
  output logic [ROW_W-1:0]  row_idx_o,
  output logic              done_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic take, word_ok, start, drop;
  job_t job;
  op_e  op_q;

  assign cmd_ready_o = !busy_o;
  assign take        = cmd_valid_i && cmd_ready_o;
  assign start       = take && word_ok;
  assign drop        = take && !word_ok;

  blk_cmd_decode #(.ROWS(ROWS)) i_decode (
    .word_i (cmd_data_i),
    .ok_o   (word_ok),
    .job_o  (job)
  );

  blk_row_gen #(.ROWS(ROWS)) i_row_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .job_i   (job),
    .busy_o  (busy_o),
    .row_o   (row_idx_o),
    .done_o  (done_o),
    .addr_o  (blk_addr_o),
    .op_o    (op_q),
    .seg_o   (seg_o)
  );

  blk_drop_cnt #(.W(DROP_W)) i_drop_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (drop),
    .cnt_o  (drop_cnt_o)
  );

  assign op_o      = op_q;
  assign row_vld_o = busy_o;

  assert_bad_hdr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && cmd_data_i[7:0] != 8'h00 |=> !busy_o && !done_o);
  assert_bad_type_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && cmd_data_i[34:33] == 2'b11 |=> !busy_o);
  assert_good_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy_o && row_vld_o && $stable(drop_cnt_o));
  assert_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> blk_addr_o == $past(cmd_data_i[11:8]));
  assert_seg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && !cmd_data_i[30] |=> seg_o == '0);
endmodule

// File: tb/test_blk_cmd_sequencer.sv
module test_blk_cmd_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [191:0] data = '0;
  logic         valid = 1'b0;
  logic         ready, busy, row_vld, done;
  logic [3:0]   addr;
  logic [1:0]   op, seg;
  logic [7:0]   row_idx;
  logic [DW-1:0] drop_cnt;

  int checks = 0;
  int errors = 0;
  int exp_drop = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_cmd_sequencer #(.DROP_W(DW)) i_blk_cmd_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .cmd_data_i(data), .cmd_valid_i(valid),
    .cmd_ready_o(ready), .blk_addr_o(addr), .op_o(op), .seg_o(seg),
    .busy_o(busy), .row_vld_o(row_vld), .row_idx_o(row_idx), .done_o(done),
    .drop_cnt_o(drop_cnt));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [191:0] rnd192();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [191:0] mk(input int hdr, input int a, input int cnt, input int sg,
                                      input bit single, input int typ, input bit flip);
    logic [191:0] w = rnd192();
    w[7:0]   = 8'(hdr);
    w[11:8]  = 4'(a);
    w[24:16] = 9'(cnt);
    w[29:28] = 2'(sg);
    w[30]    = single;
    w[34:32] = 3'(typ);
    w[36]    = flip;
    return w;
  endfunction

  task automatic model(input logic [191:0] w, output bit ok, output int eop, output int ecnt,
                       output int first, output bit down, output int eseg, output int eaddr);
    int typ = int'(w[34:32]);
    int cnt = int'(w[24:16]);
    ok = (w[7:0] == 0) && (typ <= 2) && (typ != 0 || (cnt >= 1 && cnt <= 136));
    eop = typ;
    down = (typ == 0) && w[36];
    ecnt = (typ == 0) ? cnt : 136;
    first = down ? 136 : 1;
    eseg = w[30] ? int'(w[29:28]) : 0;
    eaddr = int'(w[11:8]);
  endtask

  task automatic send(input logic [191:0] w, input bit poke);
    bit ok, down;
    int eop, ecnt, first, eseg, eaddr, r;
    model(w, ok, eop, ecnt, first, down, eseg, eaddr);
    while (!ready) @(negedge clk);
    data = w;
    valid = 1'b1;
    @(posedge clk);
    #1 valid = 1'b0;
    data = rnd192();
    @(negedge clk);
    if (!ok) begin
      exp_drop = (exp_drop < (1 << DW) - 1) ? exp_drop + 1 : exp_drop;
      chk(!busy && !row_vld && !done, "R1/R2/R3", "dropped word started", int'(busy), 0);
      chk(int'(drop_cnt) == exp_drop, "R11", "drop count", int'(drop_cnt), exp_drop);
      return;
    end
    for (int i = 0; i < ecnt; i++) begin
      r = down ? first - i : first + i;
      if (down) chk(row_vld && int'(row_idx) == r, "R6", "row index down", int'(row_idx), r);
      else if (eop == 0) chk(row_vld && int'(row_idx) == r, "R5", "row index up", int'(row_idx), r);
      else chk(row_vld && int'(row_idx) == r, "R7", "row index clear/set", int'(row_idx), r);
      if (i == 0) begin
        chk(!ready, "R4", "ready while busy", int'(ready), 0);
        chk(int'(op) == eop, "R7", "op code", int'(op), eop);
        chk(int'(addr) == eaddr, "R8", "block address", int'(addr), eaddr);
        chk(int'(seg) == eseg, "R9", "segment", int'(seg), eseg);
        chk(int'(drop_cnt) == exp_drop, "R11", "drop count on good word", int'(drop_cnt), exp_drop);
        if (poke) begin
          data = mk(0, eaddr ^ 5, 3, 0, 0, 0, 0);
          valid = 1'b1;
        end
      end
      if (i == 1 && poke) begin
        valid = 1'b0;
        chk(int'(addr) == eaddr, "R4", "address changed by stalled word", int'(addr), eaddr);
      end
      if (i == ecnt - 1 && poke) valid = 1'b0;
      @(negedge clk);
    end
    chk(done && !busy && !row_vld, "R10", "done after last row", int'(done), 1);
    @(negedge clk);
    chk(!done && !busy, "R10", "done width / no restart", int'(done), 0);
    if (poke) chk(int'(drop_cnt) == exp_drop, "R4", "stalled word counted", int'(drop_cnt), exp_drop);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(ready && !busy && !row_vld && !done, "R11", "reset ready/busy", int'(ready), 1);
    chk(drop_cnt == '0, "R11", "reset drop count", int'(drop_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    send(mk(0, 1, 136, 0, 0, 0, 0), 0);   // R5 full block up
    send(mk(0, 7, 1, 2, 1, 0, 1), 0);     // R6 single row down, R9 segment
    send(mk(0, 15, 136, 3, 0, 0, 1), 0);  // R6 full down, R9 forced zero
    send(mk(0, 2, 5, 1, 1, 0, 0), 1);     // R4 stall during sequence
    send(mk(0, 3, 0, 0, 0, 0, 0), 0);     // R2 count zero
    send(mk(0, 3, 137, 0, 0, 0, 0), 0);   // R2 count 137
    send(mk(1, 3, 10, 0, 0, 0, 0), 0);    // R1 header
    send(mk(8'h80, 3, 10, 0, 0, 1, 0), 0);// R1 header on clear
    send(mk(0, 3, 10, 0, 0, 3, 0), 0);    // R3
    send(mk(0, 3, 10, 0, 0, 7, 0), 0);    // R3
    send(mk(0, 9, 0, 0, 0, 1, 1), 0);     // R7 clear ignores count/flip
    send(mk(0, 4, 300, 3, 1, 2, 1), 0);   // R7 set, R9
    send(mk(0, 6, 136, 0, 0, 0, 0), 0);   // R5 full up again
    for (int n = 0; n < 150; n++) begin
      int hdr = ($urandom % 8 == 0) ? int'($urandom % 255) + 1 : 0;
      int typ = ($urandom % 6 == 0) ? int'($urandom % 8) : int'($urandom % 3);
      int cnt = ($urandom % 8 == 0) ? int'($urandom % 512) : int'($urandom % 136) + 1;
      send(mk(hdr, int'($urandom % 16), cnt, int'($urandom % 4), 1'($urandom), typ, 1'($urandom)),
           ($urandom % 10 == 0));
    end
    chk(int'(drop_cnt) == exp_drop, "R11", "final saturated drop count", int'(drop_cnt), exp_drop);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule